// File: doc/BRIEF.md
# Fixed-Latency Pipelined Synchronous FIFO

This block is a single-clock first-in first-out buffer built for high clock rates. The producer offers a word with `push_valid` and `push_data`. The word is taken only when the FIFO is ready and not full. The consumer does not wait for data. It raises `pop_req` to promise that it will accept one word a fixed number of cycles later (LAT). In that later cycle `pop_valid` tells it whether a word actually arrived on `pop_data`.

Back-pressure rules. On the write side, a word counts as transferred in a cycle where `push_valid`, `push_ready` are high and `push_full` is low. In any other cycle the word is dropped, so the producer must hold it and offer it again. On the read side there is no back-pressure at all. Every `pop_valid` pulse must be consumed in its own cycle, so the consumer must reserve room for LAT words of in-flight data before it raises `pop_req`. `push_ready` is computed from the occupancy that follows each edge. `push_full` is a slower, one-cycle-later view of the same fill level. The usable depth is therefore DEPTH−MARGIN entries.

LAT depends on the storage style chosen with `MEM_KIND`. The style changes how many register stages the stored word passes through on its way out. Both an asynchronous clear and a synchronous clear are provided, and both are active high.

Top module: `lat_fifo`

## Requirements
- R1: After either clear, `push_ready`=1, `push_full`=0, `pop_empty`=1 and `pop_valid`=0, and no word is stored.
- R2: Stored words leave on `pop_data` in the order they were accepted, each exactly once, in the cycle where `pop_valid`=1.
- R3: A word is stored only in a cycle with `push_valid`=1, `push_ready`=1 and `push_full`=0. In any other cycle the offered word is not stored. The usable capacity is DEPTH−MARGIN words.
- R4: `push_ready` is registered. In the cycle after an edge it is 1 exactly when the occupancy after that edge is below DEPTH−MARGIN.
- R5: `push_full` is registered and lags one cycle further. It is 1 exactly when the occupancy one cycle earlier was at least DEPTH−MARGIN.
- R6: A `pop_req` is accepted only when the occupancy at the start of its cycle is nonzero. A word written in the same cycle does not count. Each accepted request removes exactly one word.
- R7: `pop_valid` is 1 exactly LAT cycles after a cycle with an accepted request, and 0 exactly LAT cycles after any other cycle.
- R8: LAT is 5 when `MEM_KIND` is MEM_SMALL (encoding 0) and 6 when it is MEM_BLOCK (encoding 1).
- R9: `pop_empty` is 1 exactly when the occupancy one cycle earlier was zero. `pop_valid` may still pulse for up to LAT cycles after `pop_empty` rises.
- R10: An accepted write and an accepted read in the same cycle leave the occupancy unchanged, so all three flags stay steady.
- R11: Asserting `arst` clears all state at once, without waiting for an edge. `srst` clears all state at the next edge. Both discard words still in the read pipeline, and requests made while either clear is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| arst | input | 1 | Asynchronous clear, active high; release it synchronously |
| srst | input | 1 | Synchronous clear, active high |
| push_valid | input | 1 | Producer offers `push_data`; keep low during clear |
| push_data | input | DATA_W | Word offered for storage |
| push_ready | output | 1 | Write gate, high when a word may be taken |
| push_full | output | 1 | Delayed, conservative full flag |
| pop_req | input | 1 | Consumer promises to accept a word LAT cycles later |
| pop_valid | output | 1 | `pop_data` carries a word this cycle |
| pop_data | output | DATA_W | Word returned for an earlier accepted request |
| pop_empty | output | 1 | Delayed empty flag |

## Verification
A wrong occupancy count first shows on `push_ready` in the cycle after the faulty edge. It then shows on `push_full` and `pop_empty` one cycle later. A slipped read or write pointer shows as a wrong or repeated word on `pop_data` at the next `pop_valid`, at most LAT cycles after the pop that used it. A lost or extra stage in the valid chain moves a `pop_valid` pulse away from its expected cycle. Because the bench compares every port against its model on every clock, any of these faults is reported within LAT+1 cycles of the event that caused it.

// File: rtl/lat_fifo_pkg.sv
package lat_fifo_pkg;

  // Storage style: selects how many output registers sit behind the array.
  typedef enum logic {
    MEM_SMALL = 1'b0,
    MEM_BLOCK = 1'b1
  } mem_kind_e;

  // Cycles from an accepted pop request to its pop_valid pulse.
  function automatic int read_latency(mem_kind_e kind);
    return (kind == MEM_BLOCK) ? 6 : 5;
  endfunction

  // Register stages inside the storage read port.
  function automatic int store_latency(mem_kind_e kind);
    return (kind == MEM_BLOCK) ? 2 : 1;
  endfunction

endpackage

// File: rtl/lat_fifo_ctrl.sv
// Pointers, occupancy and the three registered flags.
module lat_fifo_ctrl #(
  parameter int DEPTH    = 16,
  parameter int FULL_LVL = 14,
  parameter int AW       = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          srst,
  input  logic          push_valid,
  input  logic          pop_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] occ,
  output logic          push_ready,
  output logic          push_full,
  output logic          pop_empty
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LVL       = CW'(FULL_LVL);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] occ_q, occ_nxt;
  logic          ready_q, full_q, empty_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  // Acceptance: writes need both gates, reads need a committed word.
  always_comb begin
    wr_fire = push_valid && ready_q && !full_q && !srst;
    rd_fire = pop_req && (occ_q != '0) && !srst;
  end

  always_comb begin
    unique case ({wr_fire, rd_fire})
      2'b10:   occ_nxt = occ_q + 1'b1;
      2'b01:   occ_nxt = occ_q - 1'b1;
      default: occ_nxt = occ_q;
    endcase
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      occ_q   <= '0;
      ready_q <= 1'b1;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (srst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      occ_q   <= '0;
      ready_q <= 1'b1;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (wr_fire) wptr_q <= bump(wptr_q);
      if (rd_fire) rptr_q <= bump(rptr_q);
      occ_q   <= occ_nxt;
      ready_q <= (occ_nxt < LVL);
      full_q  <= (occ_q >= LVL);
      empty_q <= (occ_q == '0);
    end
  end

  assign waddr      = wptr_q;
  assign raddr      = rptr_q;
  assign occ        = occ_q;
  assign push_ready = ready_q;
  assign push_full  = full_q;
  assign pop_empty  = empty_q;

endmodule

// File: rtl/lat_fifo_store.sv
// Storage array with a registered read port of SLAT stages.
module lat_fifo_store #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int SLAT  = 1
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          srst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd1_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      rd1_q <= '0;
    else if (srst) rd1_q <= '0;
    else if (re)   rd1_q <= mem[raddr];
  end

  generate
    if (SLAT >= 2) begin : g_outreg
      logic [W-1:0] rd2_q;
      always_ff @(posedge clk or posedge arst) begin
        if (arst)      rd2_q <= '0;
        else if (srst) rd2_q <= '0;
        else           rd2_q <= rd1_q;
      end
      assign rdata = rd2_q;
    end else begin : g_direct
      assign rdata = rd1_q;
    end
  endgenerate

endmodule

// File: rtl/lat_fifo_rdpipe.sv
// Valid chain of LAT stages and data chain completing the read latency.
module lat_fifo_rdpipe #(
  parameter int W    = 16,
  parameter int LAT  = 5,
  parameter int SLAT = 1
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         srst,
  input  logic         fire,
  input  logic [W-1:0] store_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  localparam int DST = LAT - SLAT;

  logic [LAT-1:0] vsr_q;
  logic [W-1:0]   dsr_q [DST];

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      vsr_q <= '0;
    else if (srst) vsr_q <= '0;
    else           vsr_q <= {vsr_q[LAT-2:0], fire};
  end

  generate
    for (genvar g = 0; g < DST; g++) begin : g_dstage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or posedge arst) begin
          if (arst)      dsr_q[g] <= '0;
          else if (srst) dsr_q[g] <= '0;
          else           dsr_q[g] <= store_data;
        end
      end else begin : g_body
        always_ff @(posedge clk or posedge arst) begin
          if (arst)      dsr_q[g] <= '0;
          else if (srst) dsr_q[g] <= '0;
          else           dsr_q[g] <= dsr_q[g-1];
        end
      end
    end
  endgenerate

  assign out_valid = vsr_q[LAT-1];
  assign out_data  = dsr_q[DST-1];

endmodule

// File: rtl/lat_fifo.sv
module lat_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int MARGIN = 2,
  parameter lat_fifo_pkg::mem_kind_e MEM_KIND = lat_fifo_pkg::MEM_SMALL
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              srst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              push_full,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_empty
);

  localparam int LAT      = lat_fifo_pkg::read_latency(MEM_KIND);
  localparam int SLAT     = lat_fifo_pkg::store_latency(MEM_KIND);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int FULL_LVL = DEPTH - MARGIN;

  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] occ;
  logic [DATA_W-1:0] store_data;

  lat_fifo_ctrl #(
    .DEPTH(DEPTH), .FULL_LVL(FULL_LVL), .AW(AW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .arst(arst), .srst(srst),
    .push_valid(push_valid), .pop_req(pop_req),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .waddr(waddr), .raddr(raddr), .occ(occ),
    .push_ready(push_ready), .push_full(push_full), .pop_empty(pop_empty)
  );

  lat_fifo_store #(
    .W(DATA_W), .DEPTH(DEPTH), .AW(AW), .SLAT(SLAT)
  ) u_store (
    .clk(clk), .arst(arst), .srst(srst),
    .we(wr_fire), .waddr(waddr), .wdata(push_data),
    .re(rd_fire), .raddr(raddr), .rdata(store_data)
  );

  lat_fifo_rdpipe #(
    .W(DATA_W), .LAT(LAT), .SLAT(SLAT)
  ) u_rdpipe (
    .clk(clk), .arst(arst), .srst(srst),
    .fire(rd_fire), .store_data(store_data),
    .out_valid(pop_valid), .out_data(pop_data)
  );

endmodule

// File: rtl/lat_fifo_chk.sv
module lat_fifo_chk #(
  parameter int CW       = 5,
  parameter int FULL_LVL = 14,
  parameter int LAT      = 5
) (
  input logic          clk,
  input logic          arst,
  input logic          srst,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          push_ready,
  input logic          push_full,
  input logic          pop_empty,
  input logic          pop_valid,
  input logic [CW-1:0] occ
);

  localparam int SW = $clog2(LAT + 1) + 1;

  // Cycles since the last clear, saturating at LAT.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or posedge arst) begin
    if (arst)                     since_q <= '0;
    else if (srst)                since_q <= '0;
    else if (since_q < SW'(LAT))  since_q <= since_q + 1'b1;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (arst || srst)
    occ <= CW'(FULL_LVL));

  // R3
  write_block_chk: assert property (@(posedge clk) disable iff (arst || srst)
    (push_full || !push_ready) && !rd_fire |=> occ <= $past(occ));

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (arst || srst)
    (since_q == SW'(LAT)) |-> (pop_valid == $past(rd_fire, LAT)));

  // R9
  empty_lag_chk: assert property (@(posedge clk) disable iff (arst || srst)
    (occ != '0) |=> !pop_empty);

  // R10
  rw_balance_chk: assert property (@(posedge clk) disable iff (arst || srst)
    wr_fire && rd_fire |=> occ == $past(occ));

endmodule

bind lat_fifo lat_fifo_chk #(
  .CW(CW), .FULL_LVL(FULL_LVL), .LAT(LAT)
) u_lat_fifo_chk (
  .clk(clk), .arst(arst), .srst(srst),
  .wr_fire(wr_fire), .rd_fire(rd_fire),
  .push_ready(push_ready), .push_full(push_full),
  .pop_empty(pop_empty), .pop_valid(pop_valid), .occ(occ)
);

// File: tb/test_lat_fifo.sv
`timescale 1ns/1ps
module test_lat_fifo;

  localparam int W        = 16;
  localparam int DEPTH    = 16;
  localparam int MARGIN   = 2;
  localparam int FULL_LVL = DEPTH - MARGIN;

  logic clk = 1'b0;
  logic arst = 1'b0;
  logic srst = 1'b0;
  logic push_valid = 1'b0;
  logic [W-1:0] push_data = '0;
  logic pop_req = 1'b0;

  logic rdy_a, full_a, empty_a, val_a;
  logic rdy_b, full_b, empty_b, val_b;
  logic [W-1:0] data_a, data_b;

  always #2.5 clk = ~clk;

  lat_fifo #(.DATA_W(W), .DEPTH(DEPTH), .MARGIN(MARGIN),
             .MEM_KIND(lat_fifo_pkg::MEM_SMALL)) i_lat_fifo (
    .clk(clk), .arst(arst), .srst(srst),
    .push_valid(push_valid), .push_data(push_data),
    .push_ready(rdy_a), .push_full(full_a),
    .pop_req(pop_req), .pop_valid(val_a), .pop_data(data_a), .pop_empty(empty_a));

  lat_fifo #(.DATA_W(W), .DEPTH(DEPTH), .MARGIN(MARGIN),
             .MEM_KIND(lat_fifo_pkg::MEM_BLOCK)) i_lat_fifo_blk (
    .clk(clk), .arst(arst), .srst(srst),
    .push_valid(push_valid), .push_data(push_data),
    .push_ready(rdy_b), .push_full(full_b),
    .pop_req(pop_req), .pop_valid(val_b), .pop_data(data_b), .pop_empty(empty_b));

  // Reference model: queue of stored words plus a six-deep request history.
  logic [W-1:0] mq[$];
  bit           m_rdy = 1'b1, m_full = 1'b0, m_empty = 1'b1;
  bit           vp [6];
  logic [W-1:0] dp [6];

  int total = 0, bad = 0, cyc = 0;
  int rx_a = 0, rx_b = 0;
  int lat_a = -1, lat_b = -1, req_cyc = 0;
  logic [W-1:0] wd_ctr = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic mreset();
    mq.delete();
    m_rdy = 1'b1; m_full = 1'b0; m_empty = 1'b1;
    for (int i = 0; i < 6; i++) begin vp[i] = 1'b0; dp[i] = '0; end
  endtask

  task automatic compare();
    chk(rdy_a == m_rdy,    "R4 push_ready small", rdy_a, m_rdy);
    chk(rdy_b == m_rdy,    "R4 push_ready block", rdy_b, m_rdy);
    chk(full_a == m_full,  "R5 push_full small", full_a, m_full);
    chk(full_b == m_full,  "R5 push_full block", full_b, m_full);
    chk(empty_a == m_empty, "R9 pop_empty small", empty_a, m_empty);
    chk(empty_b == m_empty, "R9 pop_empty block", empty_b, m_empty);
    chk(val_a == vp[4],    "R7 pop_valid small", val_a, vp[4]);
    chk(val_b == vp[5],    "R8 pop_valid block", val_b, vp[5]);
    if (vp[4]) chk(data_a == dp[4], "R2 pop_data small", data_a, dp[4]);
    if (vp[5]) chk(data_b == dp[5], "R2 pop_data block", data_b, dp[5]);
    if (val_a) begin rx_a++; if (lat_a < 0) lat_a = cyc - req_cyc; end
    if (val_b) begin rx_b++; if (lat_b < 0) lat_b = cyc - req_cyc; end
  endtask

  task automatic step(input bit w, input bit r, input bit s, input bit a);
    logic [W-1:0] d;
    int co;
    bit wf, rf;
    @(negedge clk);
    cyc++;
    compare();
    d = wd_ctr;
    push_valid = w; push_data = d; pop_req = r; srst = s; arst = a;
    if (w) wd_ctr++;
    if (a || s) mreset();
    else begin
      co = mq.size();
      wf = w && m_rdy && !m_full;
      rf = r && (co != 0);
      for (int i = 5; i > 0; i--) begin vp[i] = vp[i-1]; dp[i] = dp[i-1]; end
      vp[0] = rf;
      dp[0] = rf ? mq[0] : '0;
      if (rf) void'(mq.pop_front());
      if (wf) mq.push_back(d);
      m_rdy   = (mq.size() < FULL_LVL);
      m_full  = (co >= FULL_LVL);
      m_empty = (co == 0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic port_reset_state(input string tag);
    chk(rdy_a && rdy_b, tag, {rdy_a, rdy_b}, 2'b11);
    chk(!full_a && !full_b, tag, {full_a, full_b}, 2'b00);
    chk(empty_a && empty_b, tag, {empty_a, empty_b}, 2'b11);
    chk(!val_a && !val_b, tag, {val_a, val_b}, 2'b00);
  endtask

  initial begin
    int base, changes;
    bit p_rdy, p_full, p_empty;
    #1 arst = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    port_reset_state("R1 state after clear");
    idle(2);

    // R3: offer 20 words into an idle consumer; only FULL_LVL are kept.
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);
    chk(!rdy_a && full_a, "R3 write gates closed", {rdy_a, full_a}, 2'b01);
    base = rx_a;
    for (int i = 0; i < 25; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    idle(8);
    chk(rx_a - base == FULL_LVL, "R3 words kept", rx_a - base, FULL_LVL);
    chk(empty_a, "R9 empty after drain", empty_a, 1);

    // R6: write and read together on an empty FIFO; read is refused.
    base = rx_a;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    idle(8);
    chk(rx_a == base, "R6 same-cycle write not readable", rx_a - base, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    idle(8);
    chk(rx_a - base == 1, "R6 word read later", rx_a - base, 1);

    // R8: measure latency of one request on each storage style.
    step(1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);
    lat_a = -1; lat_b = -1;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    req_cyc = cyc;
    idle(10);
    chk(lat_a == 5, "R8 latency small", lat_a, 5);
    chk(lat_b == 6, "R8 latency block", lat_b, 6);

    // R10: hold level 7 with simultaneous read and write.
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);
    p_rdy = rdy_a; p_full = full_a; p_empty = empty_a;
    changes = 0;
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0);
      if (rdy_a != p_rdy || full_a != p_full || empty_a != p_empty) changes++;
    end
    chk(changes == 0, "R10 flags steady", changes, 0);
    chk(rdy_a && !empty_a, "R10 level kept", {rdy_a, empty_a}, 2'b10);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    idle(8);

    // Random traffic with three mixes.
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 700; i++)
        step($urandom_range(0, 99) < (ph == 0 ? 75 : (ph == 1 ? 30 : 50)),
             $urandom_range(0, 99) < (ph == 0 ? 35 : (ph == 1 ? 80 : 50)),
             1'b0, 1'b0);
    end

    // R11: synchronous clear with reads in flight.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    base = rx_a;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    port_reset_state("R11 srst state");
    idle(8);
    chk(rx_a == base, "R11 srst drops in-flight words", rx_a - base, 0);

    // R11: asynchronous clear takes effect between edges.
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0;
    #1 arst = 1'b1;
    mreset();
    #0.5;
    port_reset_state("R11 arst without edge");
    base = rx_a;
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    idle(8);
    chk(rx_a == base, "R11 arst drops in-flight words", rx_a - base, 0);
    chk(empty_a && rdy_a, "R1 state after arst", {empty_a, rdy_a}, 2'b11);

    // Final random burst and drain.
    for (int i = 0; i < 800; i++)
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    idle(8);
    chk(rx_a == rx_b, "R2 both styles deliver same count", rx_a, rx_b);
    chk(empty_a && empty_b, "R9 empty at end", {empty_a, empty_b}, 2'b11);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule